// File: doc/BRIEF.md
# Dual-Diagonal Parity Predictor and Corrector

This block produces the parity sub-blocks of a quasi-cyclic LDPC codeword whose parity part is dual-diagonal. Its inputs are the per-row lambda vectors, each `LIFT` bits wide, that the message part of the check matrix yields. It also takes a two-bit rate code and a start strobe. It does not solve the rows one after another from the top. Instead it forms all predicted parity vectors in one cycle, using two XOR chains. One chain runs from the top row down to the middle. The other runs from the bottom row up to the middle. In a second cycle it forms the first parity vector, P0, from the two innermost predictions. It then XORs P0 into every other prediction.

One prediction network with twelve slots serves all four rates. A reduced rate occupies only the outer slots, so it keeps the same chains and the same two-register pipeline. The results are presented with a valid flag and stay unchanged until the next start.

The parity part of the check matrix is defined as follows, for `m` active rows and `k = m/2`:
- Parity vector p0 has an identity block at rows 0, k and m-1.
- Each vector p_j (j = 1..m-1) has identity blocks at rows j-1 and j.

Top module: `dd_parity_solver`

## Requirements
- R1: After reset, `parityValid` is 0 and every bit of `parityOut` is 0 until the first result is presented.
- R2: `rateSel` 0, 1, 2 and 3 select 12, 8, 6 and 4 active rows, so k = 6, 4, 3 and 2. Row r sits in slot r when r < k, and in slot r + 12 - m otherwise. Slot s occupies bits [s*LIFT +: LIFT] of `lambdaIn` and of `parityOut`.
- R3: Each forward slot s < k outputs the XOR of the active lambdas in slots 0..s, XORed with P0. This value is parity vector p_(s+1).
- R4: Each backward slot s > 12-k outputs the XOR of the lambdas in slots s..11, XORed with P0. This value is parity vector p_(s-12+2k).
- R5: Slot 12-k outputs P0. P0 is the XOR of the innermost forward and backward predictions, which equals the XOR of all active lambdas.
- R6: Inactive slots output zero, and lambda data placed in inactive slots has no effect on any output.
- R7: With a start in cycle c and none in cycle c+1, `parityValid` is 1 in cycle c+2, and the outputs carry the result for the lambdas and rate sampled in cycle c.
- R8: While no start occurs, a raised `parityValid` stays 1 and `parityOut` stays unchanged.
- R9: A start clears `parityValid` in the following cycle. When starts are back to back, only the latest one is presented.
- R10: For every rate, the presented parity together with the lambdas satisfies all m row equations of the check matrix (zero syndrome).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Samples `lambdaIn` and `rateSel` and launches a computation |
| rateSel | input | 2 | Rate code: 0 = 1/2, 1 = 2/3, 2 = 3/4, 3 = 5/6 |
| lambdaIn | input | 12*LIFT | Lambda vectors, one per slot |
| parityOut | output | 12*LIFT | Corrected parity vectors, with P0 in slot 12-k |
| parityValid | output | 1 | Result present and stable |

## Verification
The bench drives data into the inactive slots at every reduced rate. A design that forgot to mask the inputs would corrupt P0, and with it every other slot. Each result is checked in two independent ways. The first is a row-by-row top-down reference solve. The second is a row-equation syndrome check. Together they catch a P0 formed from the wrong pair of predictions, an off-by-one in the middle slot, or a backward chain that stops one row short. The bench also issues back-to-back and held starts. A design that let a stale result through with the valid flag raised, or that did not drop the flag on a new start, fails there. Idle stretches of several cycles expose any output that drifts while valid is high.

// File: rtl/dd_parity_pkg.sv
package dd_parity_pkg;
  localparam int SLOTS = 12;
  localparam int HALF  = SLOTS / 2;

  typedef enum logic [1:0] {
    RATE_HALF           = 2'd0,
    RATE_TWO_THIRDS     = 2'd1,
    RATE_THREE_QUARTERS = 2'd2,
    RATE_FIVE_SIXTHS    = 2'd3
  } rate_e;

  typedef struct packed {
    logic loadPred;
    logic loadOut;
  } strobe_t;

  // Rows on each side of the middle for a given rate code.
  function automatic int sideRows(logic [1:0] r);
    case (r)
      2'd0:    return 6;
      2'd1:    return 4;
      2'd2:    return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic slotActive(logic [1:0] r, int s);
    int k;
    k = sideRows(r);
    return (s < k) || (s >= SLOTS - k);
  endfunction
endpackage

// File: rtl/dd_parity_ctrl.sv
module dd_parity_ctrl
  import dd_parity_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strobe,
  output logic    validOut
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend     <= 1'b0;
      validOut <= 1'b0;
    end else begin
      pend <= start;
      if (start)     validOut <= 1'b0;
      else if (pend) validOut <= 1'b1;
    end
  end

  assign strobe.loadPred = start;
  assign strobe.loadOut  = pend;
endmodule

// File: rtl/dd_parity_dpath.sv
module dd_parity_dpath
  import dd_parity_pkg::*;
#(
  parameter int LIFT = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [1:0]            rateSel,
  input  logic [SLOTS*LIFT-1:0] lambdaIn,
  output logic [SLOTS*LIFT-1:0] parityOut
);
  logic [LIFT-1:0] lam   [SLOTS];
  logic [LIFT-1:0] chain [SLOTS];
  logic [LIFT-1:0] pred  [SLOTS];
  logic [LIFT-1:0] nxt   [SLOTS];
  logic [LIFT-1:0] outQ  [SLOTS];
  logic [1:0]      rateQ;
  logic [LIFT-1:0] p0;
  int              kSide;

  // Unused slots are forced to zero so they cannot reach the chains.
  for (genvar s = 0; s < SLOTS; s++) begin : g_mask
    assign lam[s] = slotActive(rateSel, s) ? lambdaIn[s*LIFT +: LIFT] : '0;
    assign parityOut[s*LIFT +: LIFT] = outQ[s];
  end

  // Forward chain over the upper half, backward chain over the lower half.
  always_comb begin
    chain[0] = lam[0];
    for (int s = 1; s < HALF; s++) chain[s] = chain[s-1] ^ lam[s];
    chain[SLOTS-1] = lam[SLOTS-1];
    for (int s = SLOTS - 2; s >= HALF; s--) chain[s] = chain[s+1] ^ lam[s];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ <= RATE_HALF;
      for (int s = 0; s < SLOTS; s++) pred[s] <= '0;
    end else if (strobe.loadPred) begin
      rateQ <= rateSel;
      for (int s = 0; s < SLOTS; s++) pred[s] <= chain[s];
    end
  end

  // Correction stage: P0 from the two innermost predictions.
  always_comb begin
    kSide = sideRows(rateQ);
    p0    = pred[kSide-1] ^ pred[SLOTS-kSide];
    for (int s = 0; s < SLOTS; s++) begin
      if (!slotActive(rateQ, s))  nxt[s] = '0;
      else if (s == SLOTS - kSide) nxt[s] = p0;
      else                         nxt[s] = pred[s] ^ p0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SLOTS; s++) outQ[s] <= '0;
    end else if (strobe.loadOut) begin
      for (int s = 0; s < SLOTS; s++) outQ[s] <= nxt[s];
    end
  end
endmodule

// File: rtl/dd_parity_solver.sv
module dd_parity_solver
  import dd_parity_pkg::*;
#(
  parameter int LIFT = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [1:0]            rateSel,
  input  logic [SLOTS*LIFT-1:0] lambdaIn,
  output logic [SLOTS*LIFT-1:0] parityOut,
  output logic                  parityValid
);
  strobe_t strobe;

  dd_parity_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .strobe   (strobe),
    .validOut (parityValid)
  );

  dd_parity_dpath #(.LIFT(LIFT)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rateSel   (rateSel),
    .lambdaIn  (lambdaIn),
    .parityOut (parityOut)
  );
endmodule

// File: rtl/dd_parity_solver_chk.sv
module dd_parity_solver_chk
  import dd_parity_pkg::*;
#(
  parameter int LIFT = 24
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic [1:0]            rateSel,
  input logic [SLOTS*LIFT-1:0] lambdaIn,
  input logic [SLOTS*LIFT-1:0] parityOut,
  input logic                  parityValid
);
  logic [1:0]            rateSeen;
  logic [LIFT-1:0]       sumSeen;
  logic [LIFT-1:0]       sumNow;
  logic [SLOTS*LIFT-1:0] idleMask;
  logic [LIFT-1:0]       p0Slot;

  always_comb begin
    sumNow = '0;
    for (int s = 0; s < SLOTS; s++)
      if (slotActive(rateSel, s)) sumNow ^= lambdaIn[s*LIFT +: LIFT];
    for (int s = 0; s < SLOTS; s++)
      idleMask[s*LIFT +: LIFT] = slotActive(rateSeen, s) ? '0 : '1;
    p0Slot = parityOut[(SLOTS - sideRows(rateSeen))*LIFT +: LIFT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateSeen <= 2'd0;
      sumSeen  <= '0;
    end else if (start) begin
      rateSeen <= rateSel;
      sumSeen  <= sumNow;
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(start) && !start) |=> parityValid); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !parityValid); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (parityValid && !start) |=> (parityValid && $stable(parityOut))); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    parityValid |-> ((parityOut & idleMask) == '0)); // R6
  AST_P0_SUM: assert property (@(posedge clk) disable iff (!rstN)
    parityValid |-> (p0Slot == sumSeen)); // R5
endmodule

bind dd_parity_solver dd_parity_solver_chk #(.LIFT(LIFT)) i_chk (.*);

// File: tb/test_dd_parity_solver.sv
module test_dd_parity_solver;
  import dd_parity_pkg::*;
  localparam int L = 24;
  localparam int W = SLOTS * L;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   rateSel = 2'd0;
  logic [W-1:0] lambdaIn = '0;
  logic [W-1:0] parityOut;
  logic         parityValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dd_parity_solver #(.LIFT(L)) i_dd_parity_solver (
    .clk(clk), .rstN(rstN), .start(start), .rateSel(rateSel),
    .lambdaIn(lambdaIn), .parityOut(parityOut), .parityValid(parityValid)
  );

  function automatic int rowsOf(logic [1:0] r);
    case (r) 2'd0: return 12; 2'd1: return 8; 2'd2: return 6; default: return 4; endcase
  endfunction

  // R2: slot holding row r
  function automatic int slotOf(int r, int m);
    return (r < m/2) ? r : r + SLOTS - m;
  endfunction

  // Top-down sequential solve, then placement into slots (R2..R6).
  function automatic logic [W-1:0] solveRef(logic [1:0] rate, logic [W-1:0] lin);
    logic [L-1:0] p [SLOTS];
    logic [L-1:0] p0;
    logic [W-1:0] res;
    int m, k;
    m = rowsOf(rate); k = m / 2;
    p0 = '0;
    for (int r = 0; r < m; r++) p0 ^= lin[slotOf(r, m)*L +: L];
    p[1] = lin[slotOf(0, m)*L +: L] ^ p0;
    for (int r = 1; r < m - 1; r++)
      p[r+1] = lin[slotOf(r, m)*L +: L] ^ p[r] ^ ((r == k) ? p0 : '0);
    res = '0;
    for (int s = 0; s < k; s++) res[s*L +: L] = p[s+1];
    res[(SLOTS-k)*L +: L] = p0;
    for (int j = 1; j < k; j++) res[(SLOTS-k+j)*L +: L] = p[k+j];
    return res;
  endfunction

  // R10: evaluate every row equation from the presented outputs.
  function automatic int syndromeErrors(logic [1:0] rate, logic [W-1:0] lin, logic [W-1:0] pout);
    logic [L-1:0] p [SLOTS];
    logic [L-1:0] acc;
    int m, k, errs;
    m = rowsOf(rate); k = m / 2; errs = 0;
    p[0] = pout[(SLOTS-k)*L +: L];
    for (int s = 0; s < k; s++) p[s+1] = pout[s*L +: L];
    for (int j = 1; j < k; j++) p[k+j] = pout[(SLOTS-k+j)*L +: L];
    for (int r = 0; r < m; r++) begin
      acc = lin[slotOf(r, m)*L +: L];
      if (r > 0)     acc ^= p[r];
      if (r < m - 1) acc ^= p[r+1];
      if (r == 0 || r == k || r == m - 1) acc ^= p[0];
      if (acc != '0) errs++;
    end
    return errs;
  endfunction

  // Behavioural reference, advanced on every rising edge.
  logic         mValid = 0, mPend = 0;
  logic [W-1:0] mOut = '0, pendOut = '0, mLam = '0, pendLam = '0;
  logic [1:0]   mRate = 0, pendRate = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mValid = 0; mPend = 0;
    end else begin
      if (mPend) begin
        mOut = pendOut; mLam = pendLam; mRate = pendRate; mValid = !start;
      end else if (start) mValid = 0;
      if (start) begin
        pendOut = solveRef(rateSel, lambdaIn); pendLam = lambdaIn; pendRate = rateSel; mPend = 1;
      end else mPend = 0;
    end
  end

  logic prevValid = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      total++;
      if (parityValid !== mValid) begin
        bad++;
        $display("FAIL R7,R8,R9 valid: actual=%0b expected=%0b", parityValid, mValid);
      end
      if (mValid) begin
        int k;
        k = sideRows(mRate);
        for (int s = 0; s < SLOTS; s++) begin
          total++;
          if (parityOut[s*L +: L] !== mOut[s*L +: L]) begin
            bad++;
            if (s < k)
              $display("FAIL R2,R3 slot %0d: actual=%h expected=%h", s, parityOut[s*L +: L], mOut[s*L +: L]);
            else if (s == SLOTS - k)
              $display("FAIL R5 slot %0d: actual=%h expected=%h", s, parityOut[s*L +: L], mOut[s*L +: L]);
            else if (s > SLOTS - k)
              $display("FAIL R4 slot %0d: actual=%h expected=%h", s, parityOut[s*L +: L], mOut[s*L +: L]);
            else
              $display("FAIL R6 slot %0d: actual=%h expected=%h", s, parityOut[s*L +: L], mOut[s*L +: L]);
          end
        end
        if (!prevValid) begin
          int e;
          e = syndromeErrors(mRate, mLam, parityOut);
          total++;
          if (e != 0) begin
            bad++;
            $display("FAIL R10 rate %0d: actual=%0d bad rows expected=0", mRate, e);
          end
        end
      end
      prevValid = mValid;
    end
  end

  function automatic logic [W-1:0] randVec();
    logic [W-1:0] v;
    for (int b = 0; b < W; b++) v[b] = 1'($urandom % 2);
    return v;
  endfunction

  task automatic launch(logic [1:0] rate, logic [W-1:0] lin, int idle);
    @(negedge clk);
    start = 1'b1; rateSel = rate; lambdaIn = lin;
    @(negedge clk);
    start = 1'b0; lambdaIn = randVec(); rateSel = 2'($urandom % 4);
    repeat (idle) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (parityValid !== 1'b0 || parityOut !== '0) begin
      bad++;
      $display("FAIL R1 reset: actual=%0b/%h expected=0/0", parityValid, parityOut);
    end
    for (int r = 0; r < 4; r++) begin
      launch(2'(r), '0, 3);
      launch(2'(r), '1, 3);           // R6: inactive slots full of ones
      launch(2'(r), randVec(), 10);   // R8: long hold
      for (int n = 0; n < 25; n++) launch(2'(r), randVec(), 3);
    end
    // R9: back-to-back and held starts
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      start = 1'b1; rateSel = 2'($urandom % 4); lambdaIn = randVec();
      @(negedge clk);
      rateSel = 2'($urandom % 4); lambdaIn = randVec();
      @(negedge clk);
      rateSel = 2'($urandom % 4); lambdaIn = randVec();
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule